// File: doc/BRIEF.md
# Periodic Limit Counter Timer

This block is a memory-mapped periodic timer. While it is running, in timer mode and holding a non-zero limit, every enabled tick advances a count. When the count reaches the programmed limit the block raises a level interrupt and the count starts again from 1. The period is therefore exactly `limit` ticks. A limit of zero stops the timer entirely.

Software acknowledges the interrupt by reading the limit word, so a handler's read both fetches the period and clears the request. A second address aliases the limit for writing only: it changes the period without touching the interrupt flag or the running count. Writing the primary limit word restarts the period from 1 and drops any pending interrupt. The interrupt level is a parameter. A system-wide instance is built with level 10 and a per-processor instance with level 14. The register port is a simple single-cycle read/write strobe interface with registered read data.

Top module: `limit_timer`

## Requirements
- R1: After a synchronous reset, `irq` is 0 and `irq_lvl` is 0. Reads return limit 0 (word 0), count 1 (word 1), run bit 0 (word 3) and configuration 0 (word 4).
- R2: The count advances on a cycle with `tick`=1 only when the run bit is 1, the configuration word is 0 and the limit is non-zero. On such a tick with count >= limit, the count becomes 1 and `irq` becomes 1 on the following cycle. On any other such tick the count increments.
- R3: A read (`rd_en`=1) of word 0 returns the limit and clears `irq` from the next cycle.
- R4: If a wrapping tick (R2) and a word-0 read occur in the same cycle, `irq` remains 1.
- R5: A write to word 2 replaces the limit and leaves both `irq` and the count unchanged.
- R6: A write to word 0 replaces the limit, sets the count to 1 and clears `irq`. This takes priority over a tick in the same cycle.
- R7: With a limit of 0 the count holds and `irq` never rises.
- R8: Word 1 (count) is read-only. A write to it changes no state.
- R9: Word 4 stores the configuration word and reads it back. Only the value 0 selects timer mode. Any non-zero value holds the count.
- R10: `irq_lvl` equals parameter `IRQ_LEVEL` (default 10) while `irq` is 1, and 0 otherwise. Both are registered outputs.
- R11: `rdata` is updated on the clock edge that samples `rd_en` and holds its value otherwise. Word 3 returns the run bit in bit 0. Word indices 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |
| irq_lvl | output | 4 | Interrupt level while requesting, else 0 |

## Verification
The hardest case to reach is R4. A limit read must land in exactly the cycle where a tick wraps the count, or the acknowledge wins and the case is never seen. The directed stimulus loads a small limit, steps the ticks until the count sits at the limit, and then issues the read together with the wrapping tick. Random stimulus with limits of 1 to 6 and dense ticks also hits this collision repeatedly. Every cycle is compared against a bench model of the register rules.

// File: rtl/limit_timer_pkg.sv
package limit_timer_pkg;
  localparam int unsigned ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    W_LIMIT  = 3'd0,
    W_COUNT  = 3'd1,
    W_LIMNC  = 3'd2,
    W_RUN    = 3'd3,
    W_CONFIG = 3'd4
  } word_e;
endpackage

// File: rtl/limit_timer_core.sv
module limit_timer_core #(
  parameter int unsigned CNT_W  = 22,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_limit,
  input  logic              wr_alias,
  input  logic              wr_run,
  input  logic              wr_cfg,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  limit_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              run_q,
  output logic [DATA_W-1:0] cfg_q,
  output logic              flag_q,
  output logic              flag_d
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic active, wrap;
  logic [CNT_W-1:0] count_d;

  assign active = tick && run_q && (cfg_q == '0) && (limit_q != '0);
  assign wrap   = active && (count_q >= limit_q);

  always_comb begin
    count_d = count_q;
    flag_d  = flag_q;
    if (wr_limit) begin
      count_d = ONE;
      flag_d  = 1'b0;
    end else begin
      if (wrap)        count_d = ONE;
      else if (active) count_d = count_q + ONE;
      if (wrap)        flag_d  = 1'b1;
      else if (rd_ack) flag_d  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
      count_q <= ONE;
      run_q   <= 1'b0;
      cfg_q   <= '0;
      flag_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      flag_q  <= flag_d;
      if (wr_limit || wr_alias) limit_q <= wdata[CNT_W-1:0];
      if (wr_run)               run_q   <= wdata[0];
      if (wr_cfg)               cfg_q   <= wdata;
    end
  end

  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (wrap && !wr_limit) |=> (flag_q && count_q == ONE));
  assert_ack_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !wrap && !wr_limit) |=> !flag_q);
  assert_match_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && wrap && !wr_limit) |=> flag_q);
  assert_alias_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_alias && !tick && !rd_ack && !wr_limit) |=> $stable(flag_q) && $stable(count_q));
  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    wr_limit |=> (count_q == ONE && !flag_q));
  assert_zero_off_R7: assert property (@(posedge clk) disable iff (rst)
    (limit_q == '0 && !wr_limit && !wr_alias) |=> !$rose(flag_q));
endmodule

// File: rtl/limit_timer_regs.sv
module limit_timer_regs
  import limit_timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 22,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LVL_W     = 4,
  parameter int unsigned IRQ_LEVEL = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  limit_q,
  input  logic [CNT_W-1:0]  count_q,
  input  logic              run_q,
  input  logic [DATA_W-1:0] cfg_q,
  input  logic              flag_d,
  output logic              wr_limit,
  output logic              wr_alias,
  output logic              wr_run,
  output logic              wr_cfg,
  output logic              rd_ack,
  output logic [DATA_W-1:0] rdata,
  output logic [LVL_W-1:0]  irq_lvl
);
  logic [DATA_W-1:0] rmux;

  assign wr_limit = wr_en && (addr == W_LIMIT);
  assign wr_alias = wr_en && (addr == W_LIMNC);
  assign wr_run   = wr_en && (addr == W_RUN);
  assign wr_cfg   = wr_en && (addr == W_CONFIG);
  assign rd_ack   = rd_en && (addr == W_LIMIT);

  always_comb begin
    rmux = '0;
    case (addr)
      W_LIMIT, W_LIMNC: rmux = DATA_W'(limit_q);
      W_COUNT:          rmux = DATA_W'(count_q);
      W_RUN:            rmux = DATA_W'(run_q);
      W_CONFIG:         rmux = cfg_q;
      default:          rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      irq_lvl <= '0;
    end else begin
      if (rd_en) rdata <= rmux;
      irq_lvl <= flag_d ? LVL_W'(IRQ_LEVEL) : '0;
    end
  end

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  assert_run_read_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == W_RUN) |=> (rdata == DATA_W'($past(run_q))));
endmodule

// File: rtl/limit_timer.sv
module limit_timer #(
  parameter int unsigned CNT_W     = 22,
  parameter int unsigned IRQ_LEVEL = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic [3:0]  irq_lvl
);
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LVL_W  = 4;

  logic wr_limit, wr_alias, wr_run, wr_cfg, rd_ack, flag_d;
  logic [CNT_W-1:0]  limit_q, count_q;
  logic              run_q;
  logic [DATA_W-1:0] cfg_q;

  limit_timer_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_limit(wr_limit), .wr_alias(wr_alias), .wr_run(wr_run), .wr_cfg(wr_cfg),
    .rd_ack(rd_ack), .wdata(wdata),
    .limit_q(limit_q), .count_q(count_q), .run_q(run_q), .cfg_q(cfg_q),
    .flag_q(irq), .flag_d(flag_d)
  );

  limit_timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .LVL_W(LVL_W),
                     .IRQ_LEVEL(IRQ_LEVEL)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .limit_q(limit_q), .count_q(count_q), .run_q(run_q), .cfg_q(cfg_q),
    .flag_d(flag_d),
    .wr_limit(wr_limit), .wr_alias(wr_alias), .wr_run(wr_run), .wr_cfg(wr_cfg),
    .rd_ack(rd_ack), .rdata(rdata), .irq_lvl(irq_lvl)
  );

  assert_level_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (irq_lvl == 4'(IRQ_LEVEL)));
  assert_level_off_R10: assert property (@(posedge clk) disable iff (rst)
    !irq |-> (irq_lvl == 4'd0));
endmodule

// File: tb/test_limit_timer.sv
module test_limit_timer;
  localparam int unsigned CNT_W = 22;
  localparam int unsigned LEVEL = 10;

  logic clk = 1'b0;
  logic rst, tick, wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;
  logic [3:0]  irq_lvl;

  always #5 clk = ~clk;

  limit_timer #(.CNT_W(CNT_W), .IRQ_LEVEL(LEVEL)) i_limit_timer (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .irq_lvl(irq_lvl)
  );

  int checks = 0, fails = 0;
  logic [31:0] m_lim, m_cnt, m_cfg, m_rd;
  logic        m_run, m_flag;

  function automatic logic [31:0] read_val(input logic [2:0] a);
    case (a)
      3'd0, 3'd2: return m_lim;
      3'd1:       return m_cnt;
      3'd3:       return {31'b0, m_run};
      3'd4:       return m_cfg;
      default:    return 32'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic t, input logic r, input logic w,
                            input logic [2:0] a, input logic [31:0] d);
    logic act, wrp;
    act = t && m_run && (m_cfg == 0) && (m_lim != 0);
    wrp = act && (m_cnt >= m_lim);
    if (r) m_rd = read_val(a);
    if (w && a == 3'd0) begin
      m_cnt = 1; m_flag = 0;
    end else begin
      if (wrp) m_cnt = 1; else if (act) m_cnt = m_cnt + 1;
      if (wrp) m_flag = 1; else if (r && a == 3'd0) m_flag = 0;
    end
    if (w && (a == 3'd0 || a == 3'd2)) m_lim = {10'b0, d[CNT_W-1:0]};
    if (w && a == 3'd3) m_run = d[0];
    if (w && a == 3'd4) m_cfg = d;
  endtask

  task automatic step(input string tag, input logic t, input logic r, input logic w,
                      input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    tick = t; rd_en = r; wr_en = w; addr = a; wdata = d;
    model_step(t, r, w, a, d);
    @(posedge clk);
    #2;
    check({tag, " irq"}, {31'b0, irq}, {31'b0, m_flag});
    check("R10 irq_lvl", {28'b0, irq_lvl}, m_flag ? LEVEL : 0);
    check("R11 rdata", rdata, m_rd);
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    step(tag, 1'b0, 1'b1, 1'b0, a, 32'b0);
  endtask
  task automatic wr(input string tag, input logic [2:0] a, input logic [31:0] d);
    step(tag, 1'b0, 1'b0, 1'b1, a, d);
  endtask
  task automatic ticks(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b0, 1'b0, 3'd0, 32'b0);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1234;
    void'($urandom(seed));
    rst = 1; tick = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    m_lim = 0; m_cnt = 1; m_cfg = 0; m_rd = 0; m_run = 0; m_flag = 0;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 0);
    rd("R1", 3'd0); check("R1 limit", rdata, 0);
    rd("R1", 3'd1); check("R1 count", rdata, 1);
    rd("R1", 3'd3); check("R1 run", rdata, 0);
    rd("R1", 3'd4); check("R1 cfg", rdata, 0);
    // R7 zero limit: running but no counting
    wr("R7", 3'd3, 1);
    ticks("R7", 8);
    rd("R7", 3'd1); check("R7 count held", rdata, 1);
    // R2 period of 3 ticks
    wr("R6", 3'd0, 3);
    ticks("R2", 2);
    check("R2 no irq before limit", {31'b0, irq}, 0);
    ticks("R2", 1);
    check("R2 irq at limit", {31'b0, irq}, 1);
    rd("R2", 3'd1); check("R2 count restart", rdata, 1);
    // R3 ack by reading limit
    rd("R3", 3'd0); check("R3 limit value", rdata, 3);
    check("R3 cleared", {31'b0, irq}, 0);
    // R4 wrap and ack in same cycle
    ticks("R4", 2);
    step("R4", 1'b1, 1'b1, 1'b0, 3'd0, 0);
    check("R4 match wins", {31'b0, irq}, 1);
    // R5 alias write keeps flag and count
    ticks("R5", 1);
    wr("R5", 3'd2, 5);
    check("R5 flag kept", {31'b0, irq}, 1);
    rd("R5", 3'd1); check("R5 count kept", rdata, 2);
    rd("R5", 3'd2); check("R5 limit", rdata, 5);
    // R6 write limit with tick same cycle
    step("R6", 1'b1, 1'b0, 1'b1, 3'd0, 4);
    check("R6 flag clear", {31'b0, irq}, 0);
    rd("R6", 3'd1); check("R6 count one", rdata, 1);
    // R8 count write ignored
    ticks("R8", 1);
    wr("R8", 3'd1, 32'h77);
    rd("R8", 3'd1); check("R8 count", rdata, 2);
    // R9 config non-zero holds count
    wr("R9", 3'd4, 32'h5);
    rd("R9", 3'd4); check("R9 cfg readback", rdata, 5);
    ticks("R9", 6);
    rd("R9", 3'd1); check("R9 frozen", rdata, 2);
    wr("R9", 3'd4, 0);
    // R11 unmapped word
    rd("R11", 3'd6); check("R11 unmapped", rdata, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      int k;
      k = $urandom_range(0, 9);
      a = 3'($urandom_range(0, 7));
      if (k < 6) step("R2 rnd", 1'b1, 1'b0, 1'b0, 3'd0, 0);
      else if (k < 8) step("R3 rnd", $urandom_range(0, 1) == 1, 1'b1, 1'b0, a, 0);
      else step("R6 rnd", $urandom_range(0, 1) == 1, 1'b0, 1'b1, a,
                (a == 3'd4 || a == 3'd3) ? 32'($urandom_range(0, 1)) :
                32'($urandom_range(0, 6)));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule